// File: doc/BRIEF.md
# Memory Remap Address Translator

This block sits between a bus master and the downstream address decoder and rewrites each 32-bit address on the fly. A single configuration word controls two independent exchanges of address windows. The external-memory swap exchanges the 256 MiB windows of the SDRAM controller and the NOR/PSRAM controller, so that code can run from SDRAM through the low window. The flash swap exchanges the two 1 MiB flash banks, and it does so on the main-bus alias and on the tightly-coupled alias at the same time.

The configuration word also reports, read-only, which of two boot address options was used. That value is taken from an input pin at the first clock after reset is released. Alongside the rewritten address, the translator emits a region tag that names the physical target. The translation path is purely combinational. A configuration write takes effect from the clock edge that accepts it.

Top module: `remap_xlat_top`

## Requirements
- R1: After reset the word at offset 0 reads as zero except for bit 0. Bits 31:12, bit 9 and bits 7:1 always read as zero. A read at any other offset returns zero.
- R2: With swap field bits 11:10 = 00, addresses pass through unchanged. The region tag is 5 (NOR) for 0x6xxx_xxxx, 3 (SDRAM bank 1) for 0xCxxx_xxxx, 4 (SDRAM bank 2) for 0xDxxx_xxxx, and 0 for 0x7xxx_xxxx.
- R3: With swap field = 01, four exchanges apply. 0x6xxx_xxxx goes to 0xCxxx_xxxx with tag 3. 0x7xxx_xxxx goes to 0xDxxx_xxxx with tag 4. 0xCxxx_xxxx goes to 0x6xxx_xxxx with tag 5. 0xDxxx_xxxx goes to 0x7xxx_xxxx with tag 0. Bits 27:0 are kept.
- R4: A write that carries swap code 10 or 11 leaves the swap field at its previous value. The other fields of the same write still take effect.
- R5: With bit 8 = 0, the flash windows pass through unchanged. 0x080x_xxxx and 0x002x_xxxx are tagged 1 (bank 1). 0x081x_xxxx and 0x003x_xxxx are tagged 2 (bank 2).
- R6: With bit 8 = 1, the two flash windows exchange base on both aliases: 0x080↔0x081 on bits 31:20 and 0x002↔0x003. The 1 MiB offset is kept, and the tag names the physical bank reached.
- R7: Bit 0 reads the boot pin as sampled at the first clock after reset release. Later pin changes and register writes do not alter it.
- R8: An address in none of the windows passes through unchanged with tag 0.
- R9: A write at a nonzero offset changes no configuration field.
- R10: Translation has no latency. A write changes the translation starting from the clock edge that accepts it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel_i | input | 1 | Boot option pin, sampled after reset release |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration byte offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data (combinational on cfg_addr_i) |
| addr_i | input | 32 | Incoming bus address |
| addr_o | output | 32 | Translated address |
| region_o | output | 3 | Physical region tag (0 none, 1/2 flash banks, 3/4 SDRAM banks, 5 NOR) |

## Verification
The bench builds the block with its default CFG_AW of 8. This puts offset 4 within reach, which is used to show that writes at a foreign offset are dropped and that reads there return zero. All window bases and sizes are fixed package constants, so the bench probes both ends of each window, including the last byte of a flash bank and the first address past it. The boot pin is held high across reset release and then driven low. This separates the captured value from the live pin level.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int AW        = 32;
    localparam int NUM_PAIRS = 4;

    typedef enum logic [2:0] {
        RG_NONE   = 3'd0,
        RG_FLASH1 = 3'd1,
        RG_FLASH2 = 3'd2,
        RG_SDRAM1 = 3'd3,
        RG_SDRAM2 = 3'd4,
        RG_NOR    = 3'd5
    } region_e;

    // Window pairs: side A and side B exchange when the pair's swap is on.
    localparam logic [AW-1:0] PAIR_BASE_A [NUM_PAIRS] =
        '{32'h6000_0000, 32'h7000_0000, 32'h0800_0000, 32'h0020_0000};
    localparam logic [AW-1:0] PAIR_BASE_B [NUM_PAIRS] =
        '{32'hC000_0000, 32'hD000_0000, 32'h0810_0000, 32'h0030_0000};
    localparam int PAIR_WIN_LOG2 [NUM_PAIRS] = '{28, 28, 20, 20};
    localparam bit PAIR_IS_FLASH [NUM_PAIRS] = '{1'b0, 1'b0, 1'b1, 1'b1};
    localparam region_e PAIR_REG_A [NUM_PAIRS] = '{RG_NOR,    RG_NONE,   RG_FLASH1, RG_FLASH1};
    localparam region_e PAIR_REG_B [NUM_PAIRS] = '{RG_SDRAM1, RG_SDRAM2, RG_FLASH2, RG_FLASH2};

    localparam int FLASH_WIN_LOG2 = 20;

    // Field positions inside the configuration word
    localparam int EXT_SWAP_LSB = 10;
    localparam int FLASH_SWAP_BIT = 8;
    localparam int BOOT_BIT = 0;

    typedef struct packed {
        logic [1:0] ext_code;
        logic       flash_swap;
        logic       boot;
        logic       armed;
    } cfg_state_t;
endpackage

// File: rtl/remap_cfg_reg.sv
module remap_cfg_reg
    import remap_pkg::*;
#(
    parameter int CFG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_sel_i,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [AW-1:0]     cfg_wdata_i,
    output logic [AW-1:0]     cfg_rdata_o,
    output logic              ext_swap_o,
    output logic              flash_swap_o
);
    cfg_state_t state_d, state_q;
    logic       sel_main;

    assign sel_main = (cfg_addr_i == '0);

    always_comb begin
        state_d = state_q;
        if (!state_q.armed) begin
            state_d.boot  = boot_sel_i;
            state_d.armed = 1'b1;
        end
        if (cfg_we_i && sel_main) begin
            state_d.flash_swap = cfg_wdata_i[FLASH_SWAP_BIT];
            if (!cfg_wdata_i[EXT_SWAP_LSB+1])
                state_d.ext_code = cfg_wdata_i[EXT_SWAP_LSB +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        cfg_rdata_o = '0;
        if (sel_main) begin
            cfg_rdata_o[EXT_SWAP_LSB +: 2]  = state_q.ext_code;
            cfg_rdata_o[FLASH_SWAP_BIT]     = state_q.flash_swap;
            cfg_rdata_o[BOOT_BIT]           = state_q.boot;
        end
    end

    assign ext_swap_o   = (state_q.ext_code == 2'b01);
    assign flash_swap_o = state_q.flash_swap;

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.ext_code[1]);  // R4
    AST_FLASH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && sel_main) |=> (flash_swap_o == $past(cfg_wdata_i[FLASH_SWAP_BIT])));  // R6
    AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.armed && $past(state_q.armed)) |-> $stable(state_q.boot));  // R7
    AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && !sel_main) |=> ($stable(ext_swap_o) && $stable(flash_swap_o)));  // R9
endmodule

// File: rtl/remap_pair.sv
module remap_pair
    import remap_pkg::*;
#(
    parameter logic [AW-1:0] BASE_A   = 32'h6000_0000,
    parameter logic [AW-1:0] BASE_B   = 32'hC000_0000,
    parameter int            WIN_LOG2 = 28
) (
    input  logic [AW-1:0] addr_i,
    input  logic          swap_i,
    output logic          hit_o,
    output logic          side_b_o,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] LO_MASK = (AW'(1) << WIN_LOG2) - AW'(1);
    localparam logic [AW-1:0] HI_MASK = ~LO_MASK;

    logic in_a, in_b;

    assign in_a     = ((addr_i & HI_MASK) == (BASE_A & HI_MASK));
    assign in_b     = ((addr_i & HI_MASK) == (BASE_B & HI_MASK));
    assign hit_o    = in_a | in_b;
    assign side_b_o = in_b ^ swap_i;
    assign addr_o   = ((side_b_o ? BASE_B : BASE_A) & HI_MASK) | (addr_i & LO_MASK);
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
    import remap_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_swap_i,
    input  logic          flash_swap_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o,
    output region_e       region_o
);
    logic [NUM_PAIRS-1:0] hit, side_b;
    logic [AW-1:0]        pair_addr [NUM_PAIRS];

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        remap_pair #(
            .BASE_A   (PAIR_BASE_A[g]),
            .BASE_B   (PAIR_BASE_B[g]),
            .WIN_LOG2 (PAIR_WIN_LOG2[g])
        ) u_pair (
            .addr_i   (addr_i),
            .swap_i   (PAIR_IS_FLASH[g] ? flash_swap_i : ext_swap_i),
            .hit_o    (hit[g]),
            .side_b_o (side_b[g]),
            .addr_o   (pair_addr[g])
        );
    end

    always_comb begin
        addr_o   = addr_i;
        region_o = RG_NONE;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (hit[i]) begin
                addr_o   = pair_addr[i];
                region_o = side_b[i] ? PAIR_REG_B[i] : PAIR_REG_A[i];
            end
        end
    end

    localparam logic [AW-1:0] FLASH_LO = (AW'(1) << FLASH_WIN_LOG2) - AW'(1);

    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));  // R8
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> (addr_o == addr_i && region_o == RG_NONE));  // R8
    AST_FLASH_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (region_o == RG_FLASH1 || region_o == RG_FLASH2) |->
        ((addr_o & FLASH_LO) == (addr_i & FLASH_LO)));  // R6
    AST_EXT_TOP_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (region_o == RG_SDRAM1) |-> (addr_o[31:28] == 4'hC));  // R3
endmodule

// File: rtl/remap_xlat_top.sv
module remap_xlat_top
    import remap_pkg::*;
#(
    parameter int CFG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_sel_i,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [31:0]       cfg_wdata_i,
    output logic [31:0]       cfg_rdata_o,
    input  logic [31:0]       addr_i,
    output logic [31:0]       addr_o,
    output logic [2:0]        region_o
);
    logic    ext_swap, flash_swap;
    region_e region;

    remap_cfg_reg #(.CFG_AW(CFG_AW)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_sel_i   (boot_sel_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_addr_i   (cfg_addr_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .cfg_rdata_o  (cfg_rdata_o),
        .ext_swap_o   (ext_swap),
        .flash_swap_o (flash_swap)
    );

    remap_xlate u_xlate (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_swap_i   (ext_swap),
        .flash_swap_i (flash_swap),
        .addr_i       (addr_i),
        .addr_o       (addr_o),
        .region_o     (region)
    );

    assign region_o = region;
endmodule

// File: tb/remap_xlat_top_bench.sv
module remap_xlat_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_sel_i = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic [7:0]  cfg_addr_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] cfg_rdata_o;
    logic [31:0] addr_i = '0;
    logic [31:0] addr_o;
    logic [2:0]  region_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    remap_xlat_top u_remap_xlat_top (
        .clk(clk), .rst_n(rst_n), .boot_sel_i(boot_sel_i),
        .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
        .cfg_rdata_o(cfg_rdata_o), .addr_i(addr_i), .addr_o(addr_o), .region_o(region_o)
    );

    task automatic chk_xl(input logic [31:0] a, input logic [31:0] ea,
                          input logic [2:0] er, input string req);
        addr_i = a;
        #1;
        checks++;
        if (addr_o !== ea || region_o !== er) begin
            errors++;
            $display("FAIL %s addr %h: got %h/%0d expected %h/%0d", req, a, addr_o, region_o, ea, er);
        end
    endtask

    task automatic chk_rd(input logic [7:0] off, input logic [31:0] exp, input string req);
        cfg_addr_i = off;
        #1;
        checks++;
        if (cfg_rdata_o !== exp) begin
            errors++;
            $display("FAIL %s read @%h: got %h expected %h", req, off, cfg_rdata_o, exp);
        end
        cfg_addr_i = '0;
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        cfg_addr_i = off; cfg_wdata_i = d; cfg_we_i = 1'b1;
        @(negedge clk);
        cfg_we_i = 1'b0; cfg_addr_i = '0;
    endtask

    task automatic t_reset;
        chk_rd(8'h00, 32'h0000_0001, "R1/R7 reset");
        chk_rd(8'h04, 32'h0, "R1 other offset");
        chk_xl(32'h6123_4567, 32'h6123_4567, 3'd5, "R2 nor");
        chk_xl(32'hC000_0010, 32'hC000_0010, 3'd3, "R2 sdram1");
        chk_xl(32'hD0AB_CDEF, 32'hD0AB_CDEF, 3'd4, "R2 sdram2");
        chk_xl(32'h7000_0004, 32'h7000_0004, 3'd0, "R2 gap");
    endtask

    task automatic t_flash_default;
        chk_xl(32'h0801_2345, 32'h0801_2345, 3'd1, "R5 main bank1");
        chk_xl(32'h0810_0004, 32'h0810_0004, 3'd2, "R5 main bank2");
        chk_xl(32'h0020_0008, 32'h0020_0008, 3'd1, "R5 tcm bank1");
        chk_xl(32'h003F_FFFF, 32'h003F_FFFF, 3'd2, "R5 tcm bank2 top");
    endtask

    task automatic t_outside;
        chk_xl(32'h2000_0000, 32'h2000_0000, 3'd0, "R8 sram");
        chk_xl(32'h0820_0000, 32'h0820_0000, 3'd0, "R8 past flash");
        chk_xl(32'h0040_0000, 32'h0040_0000, 3'd0, "R8 past tcm");
    endtask

    task automatic t_boot_ro;
        @(negedge clk); boot_sel_i = 1'b0;
        repeat (3) @(negedge clk);
        chk_rd(8'h00, 32'h0000_0001, "R7 pin change");
        wr(8'h00, 32'h0000_0000);
        chk_rd(8'h00, 32'h0000_0001, "R7 write bit0");
    endtask

    task automatic t_reserved_code;
        wr(8'h00, 32'hFFFF_FFFF);
        chk_rd(8'h00, 32'h0000_0101, "R4/R1 code 11 dropped, reserved zero");
        chk_xl(32'h6000_0000, 32'h6000_0000, 3'd5, "R4 no ext swap");
    endtask

    task automatic t_flash_swap;
        chk_xl(32'h0801_2345, 32'h0811_2345, 3'd2, "R6 main b1->b2");
        chk_xl(32'h0812_3456, 32'h0802_3456, 3'd1, "R6 main b2->b1");
        chk_xl(32'h0020_0100, 32'h0030_0100, 3'd2, "R6 tcm b1->b2");
        chk_xl(32'h0030_0200, 32'h0020_0200, 3'd1, "R6 tcm b2->b1");
        chk_xl(32'h080F_FFFF, 32'h081F_FFFF, 3'd2, "R6 window top");
    endtask

    task automatic t_ext_swap;
        @(negedge clk);
        cfg_wdata_i = 32'h0000_0400; cfg_we_i = 1'b1;
        chk_xl(32'h6012_3456, 32'h6012_3456, 3'd5, "R10 before edge");
        @(negedge clk);
        cfg_we_i = 1'b0;
        chk_xl(32'h6012_3456, 32'hC012_3456, 3'd3, "R3/R10 low->sdram1");
        chk_rd(8'h00, 32'h0000_0401, "R3 readback");
        chk_xl(32'h7ABC_0000, 32'hDABC_0000, 3'd4, "R3 sdram2");
        chk_xl(32'hC000_0040, 32'h6000_0040, 3'd5, "R3 nor");
        chk_xl(32'hD000_0001, 32'h7000_0001, 3'd0, "R3 high gap");
        chk_xl(32'h0801_2345, 32'h0801_2345, 3'd1, "R5 flash back default");
    endtask

    task automatic t_reserved_after_swap;
        wr(8'h00, 32'h0000_0C00);
        chk_rd(8'h00, 32'h0000_0401, "R4 code 11 keeps 01");
        wr(8'h00, 32'h0000_0900);
        chk_rd(8'h00, 32'h0000_0501, "R4 code 10 keeps 01, flash taken");
        chk_xl(32'h6000_0000, 32'hC000_0000, 3'd3, "R4 swap kept");
        wr(8'h00, 32'h0000_0400);
    endtask

    task automatic t_other_offset;
        wr(8'h04, 32'h0000_0000);
        chk_rd(8'h00, 32'h0000_0401, "R9 foreign write");
        chk_xl(32'hC000_0000, 32'h6000_0000, 3'd5, "R9 swap intact");
        chk_rd(8'h04, 32'h0, "R1 foreign read");
    endtask

    task automatic t_back_default;
        wr(8'h00, 32'h0000_0000);
        chk_rd(8'h00, 32'h0000_0001, "R3 clear");
        chk_xl(32'h6000_0000, 32'h6000_0000, 3'd5, "R2 restored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_flash_default();
        t_outside();
        t_boot_ro();
        t_reserved_code();
        t_flash_swap();
        t_ext_swap();
        t_reserved_after_swap();
        t_other_offset();
        t_back_default();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule